// File: doc/BRIEF.md
# Wide-to-Narrow Serial Control Bridge

This block lets a 16-bit host reach the registers of two downstream slave chips that have no host port of their own. The host hands it 16-bit words one at a time. The first word of each transaction is an address word. Bit 15 of that word marks the transaction as a read (1) or a write (0). Bit 8 picks the slave chip, and bits 7..0 give the slave register address. A write needs a second 16-bit word carrying the data. A read needs none.

Once the bridge has the whole transaction, it narrows it to an 8-bit address and 8-bit data. It then runs one serial frame on a four-wire master link: a serial clock, data out, data in, and one active-low select per slave. Each frame is 17 bits long, most significant bit first: a direction bit, the 8 address bits, then the 8 data bits. During the data bits of a read, the slave answers on the data-in line. The answer comes back to the host as a 16-bit word with the upper byte cleared.

While a frame is in flight the bridge drops its ready flag. Words offered during that time are neither taken nor remembered. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `ctl_narrow_bridge`

## Requirements
- R1: After reset, `hw_ready` is 1, `cs_n` is 2'b11, `sclk` is 0 and `rd_valid` is 0; `sclk` stays 0 whenever no select is low.
- R2: A word accepted with bit 15 = 0 (write) starts no frame. `cs_n` stays 2'b11 and `hw_ready` stays 1 until a second word (the data word) is accepted.
- R3: A word accepted with bit 15 = 1 (read) starts a frame without any further word; a select goes low within 3 clock cycles.
- R4: Each frame carries 17 bits on `sdo`, valid at each rising `sclk` edge, in this order: direction (1 = read, 0 = write), address bits 7..0, then data bits 7..0, MSB first. During a read the data bits on `sdo` are 0.
- R5: Address bit 8 selects the slave: `cs_n[0]` low for 0, `cs_n[1]` low for 1. At most one select is low, and it stays low for the whole frame.
- R6: On a write, only bits 7..0 of the data word reach the slave; bits 15..8 have no effect.
- R7: On a read, the byte shifted in on `sdi` during the 8 data bits, sampled at rising `sclk`, appears on `rd_data` zero-extended to 16 bits during a one-cycle `rd_valid` pulse.
- R8: `hw_ready` is 0 while a frame is in flight. Words offered then are ignored, and the next accepted word is treated as a fresh address word.
- R9: A select stays low for exactly `34*HALF_DIV` clock cycles per frame; each `sclk` half period is `HALF_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_valid | input | 1 | Host offers a word |
| hw_word | input | 16 | Host word: address word first, then data word for writes |
| hw_ready | output | 1 | Bridge can take a word this cycle (low while busy) |
| rd_valid | output | 1 | One-cycle pulse: read result valid |
| rd_data | output | 16 | Read result, upper byte zero |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data to slaves |
| sdi | input | 1 | Serial data from slaves |
| cs_n | output | 2 | Active-low slave selects, one per chip |

## Verification
Two events can land in the same cycle: the end of a frame, and a host word already waiting for the bridge to become ready. The bench queues a second read behind a read in flight and keeps `hw_valid` high through the first frame. It then checks that both frames appear one after the other, each with its own address and chip, and that each returns its own byte. A second scenario offers a write address word only while the bridge is busy and withdraws it before the frame ends. A following read must then be decoded as a fresh address; if the stray word had been taken, that read word would be treated as write data.

// File: rtl/ctl_narrow_pkg.sv
package ctl_narrow_pkg;

    localparam int HOST_W     = 16;
    localparam int SLV_AW     = 8;
    localparam int SLV_DW     = 8;
    localparam int RW_BIT     = 15;
    localparam int CHIP_BIT   = 8;
    localparam int NUM_SLAVES = 2;
    localparam int CHIP_W     = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1;
    localparam int FRAME_BITS = 1 + SLV_AW + SLV_DW;
    localparam int BC_W       = $clog2(FRAME_BITS);

    typedef struct packed {
        logic              is_read;
        logic [CHIP_W-1:0] chip;
        logic [SLV_AW-1:0] addr;
        logic [SLV_DW-1:0] data;
    } slv_req_t;

    typedef enum logic [1:0] {
        F_ADDR = 2'd0,
        F_DATA = 2'd1,
        F_WAIT = 2'd2
    } front_st_t;

    // Serial frame image, first bit out at the MSB.
    function automatic logic [FRAME_BITS-1:0] pack_frame(slv_req_t r);
        return {r.is_read, r.addr, r.data};
    endfunction

endpackage

// File: rtl/ctl_narrow_front.sv
module ctl_narrow_front
    import ctl_narrow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_valid,
    input  logic [HOST_W-1:0] hw_word,
    output logic              hw_ready,
    input  logic              ser_done,
    output logic              start,
    output slv_req_t          req
);

    front_st_t state;
    logic      unused_bits;

    assign unused_bits = ^{hw_word[RW_BIT-1:CHIP_BIT+1]};
    assign hw_ready    = (state != F_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= F_ADDR;
            start <= 1'b0;
            req   <= '0;
        end else begin
            start <= 1'b0;
            case (state)
                F_ADDR: begin
                    if (hw_valid) begin
                        req.is_read <= hw_word[RW_BIT];
                        req.chip    <= hw_word[CHIP_BIT +: CHIP_W];
                        req.addr    <= hw_word[SLV_AW-1:0];
                        req.data    <= '0;
                        if (hw_word[RW_BIT]) begin
                            start <= 1'b1;
                            state <= F_WAIT;
                        end else begin
                            state <= F_DATA;
                        end
                    end
                end
                F_DATA: begin
                    if (hw_valid) begin
                        req.data <= hw_word[SLV_DW-1:0];
                        start    <= 1'b1;
                        state    <= F_WAIT;
                    end
                end
                F_WAIT: begin
                    if (ser_done) state <= F_ADDR;
                end
                default: state <= F_ADDR;
            endcase
        end
    end

endmodule

// File: rtl/ctl_narrow_serial.sv
module ctl_narrow_serial
    import ctl_narrow_pkg::*;
#(
    parameter int HALF_DIV = 2
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  slv_req_t              req,
    input  logic                  sdi,
    output logic                  sclk,
    output logic                  sdo,
    output logic [NUM_SLAVES-1:0] cs_n,
    output logic                  done,
    output logic                  rd_valid,
    output logic [HOST_W-1:0]     rd_data
);

    localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic                  active;
    logic                  rd_q;
    logic [CHIP_W-1:0]     chip_q;
    logic [FRAME_BITS-1:0] tx;
    logic [SLV_DW-1:0]     rx;
    logic [BC_W-1:0]       bit_cnt;
    logic [PH_W-1:0]       ph_cnt;
    logic                  sclk_q;

    assign sclk = sclk_q;
    assign sdo  = active & tx[FRAME_BITS-1];

    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_sel
        assign cs_n[i] = !(active && (chip_q == CHIP_W'(i)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            rd_q     <= 1'b0;
            chip_q   <= '0;
            tx       <= '0;
            rx       <= '0;
            bit_cnt  <= '0;
            ph_cnt   <= '0;
            sclk_q   <= 1'b0;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    tx      <= pack_frame(req);
                    chip_q  <= req.chip;
                    rd_q    <= req.is_read;
                    bit_cnt <= '0;
                    ph_cnt  <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (ph_cnt != PH_W'(HALF_DIV - 1)) begin
                ph_cnt <= ph_cnt + 1'b1;
            end else begin
                ph_cnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx     <= {rx[SLV_DW-2:0], sdi};
                end else begin
                    sclk_q <= 1'b0;
                    tx     <= {tx[FRAME_BITS-2:0], 1'b0};
                    if (bit_cnt == BC_W'(FRAME_BITS - 1)) begin
                        active   <= 1'b0;
                        done     <= 1'b1;
                        rd_valid <= rd_q;
                        if (rd_q) rd_data <= {{(HOST_W - SLV_DW){1'b0}}, rx};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ctl_narrow_bridge.sv
module ctl_narrow_bridge
    import ctl_narrow_pkg::*;
#(
    parameter int HALF_DIV = 2
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        hw_valid,
    input  logic [15:0] hw_word,
    output logic        hw_ready,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        sclk,
    output logic        sdo,
    input  logic        sdi,
    output logic [1:0]  cs_n
);

    slv_req_t req;
    logic     start;
    logic     ser_done;

    ctl_narrow_front u_front (
        .clk      (clk),
        .rst      (rst),
        .hw_valid (hw_valid),
        .hw_word  (hw_word),
        .hw_ready (hw_ready),
        .ser_done (ser_done),
        .start    (start),
        .req      (req)
    );

    ctl_narrow_serial #(.HALF_DIV(HALF_DIV)) u_serial (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .sdi      (sdi),
        .sclk     (sclk),
        .sdo      (sdo),
        .cs_n     (cs_n),
        .done     (ser_done),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/ctl_narrow_bridge_chk.sv
module ctl_narrow_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        hw_ready,
    input logic        rd_valid,
    input logic [15:0] rd_data,
    input logic        sclk,
    input logic [1:0]  cs_n
);

    // R5
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R5
    select_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n != 2'b11) |=> ((cs_n == $past(cs_n)) || (cs_n == 2'b11)));

    // R8
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n != 2'b11) |-> !hw_ready);

    // R1
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n == 2'b11) |-> !sclk);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R7
    rd_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[15:8] == 8'h00));

endmodule

bind ctl_narrow_bridge ctl_narrow_bridge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .hw_ready (hw_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .sclk     (sclk),
    .cs_n     (cs_n)
);

// File: tb/ctl_narrow_bridge_tb.sv
module ctl_narrow_bridge_tb;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_valid = 1'b0;
    logic [15:0] hw_word = '0;
    logic        hw_ready;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sclk;
    logic        sdo;
    logic        sdi = 1'b0;
    logic [1:0]  cs_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ctl_narrow_bridge #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst(rst), .hw_valid(hw_valid), .hw_word(hw_word),
        .hw_ready(hw_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_n(cs_n)
    );

    // ---------------- behavioural slave pair ----------------
    logic [7:0]  smem [2][256];
    logic [16:0] s_sh = '0;
    int          s_bits = 0;
    logic        s_rw = 1'b0;
    logic [7:0]  s_addr = '0;
    int          s_chip = 0;
    int          frame_cnt = 0;
    logic        last_rw = 1'b0;
    logic [7:0]  last_addr = '0;
    logic [7:0]  last_data = '0;
    int          last_chip = -1;

    function automatic logic [7:0] init_val(int c, int a);
        return 8'(a) ^ ((c != 0) ? 8'hC3 : 8'h5A);
    endfunction

    initial begin
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++) smem[c][a] = init_val(c, a);
    end

    always @(posedge sclk) begin
        if (cs_n != 2'b11) begin
            s_chip = (cs_n == 2'b10) ? 0 : 1;
            s_sh   = {s_sh[15:0], sdo};
            s_bits = s_bits + 1;
            if (s_bits == 9) begin
                s_rw   = s_sh[8];
                s_addr = s_sh[7:0];
            end
            if (s_bits == 17) begin
                last_rw   = s_sh[16];
                last_addr = s_sh[15:8];
                last_data = s_sh[7:0];
                last_chip = s_chip;
                if (!s_rw) smem[s_chip][s_addr] = s_sh[7:0];
                frame_cnt = frame_cnt + 1;
                s_bits = 0;
            end
        end
    end

    always @(negedge sclk) begin
        if (s_rw && s_bits >= 9 && s_bits <= 16)
            sdi = smem[s_chip][s_addr][7 - (s_bits - 9)];
        else
            sdi = 1'b0;
    end

    // ---------------- output monitors (sampled at negedge) ----------------
    int          cs_run = 0;
    int          last_run = 0;
    int          rd_cnt = 0;
    logic [15:0] last_rd = '0;
    logic [15:0] prev_rd = '0;

    always @(negedge clk) begin
        if (cs_n != 2'b11) cs_run = cs_run + 1;
        else if (cs_run != 0) begin
            last_run = cs_run;
            cs_run = 0;
        end
        if (rd_valid) begin
            prev_rd = last_rd;
            last_rd = rd_data;
            rd_cnt  = rd_cnt + 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        logic rdy;
        @(negedge clk);
        hw_valid = 1'b1;
        hw_word  = w;
        forever begin
            rdy = hw_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic wait_frames(input int n, input int base);
        while (frame_cnt < base + n) @(negedge clk);
        while (!(hw_ready && cs_n == 2'b11)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk("R1 hw_ready", 32'(hw_ready), 1);
        chk("R1 cs_n", 32'(cs_n), 2'b11);
        chk("R1 sclk", 32'(sclk), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
    endtask

    task automatic t_write_then_read_chip1();
        int base = frame_cnt;
        int rb;
        send_word(16'h1512);
        repeat (6) @(negedge clk);
        chk("R2 no frame on write address", 32'(cs_n), 2'b11);
        chk("R2 ready for data word", 32'(hw_ready), 1);
        send_word(16'hAB77);
        wait_frames(1, base);
        chk("R4 write direction bit", 32'(last_rw), 0);
        chk("R4 write address", 32'(last_addr), 8'h12);
        chk("R6 low data byte only", 32'(last_data), 8'h77);
        chk("R5 chip 1 selected", 32'(last_chip), 1);
        base = frame_cnt;
        rb = rd_cnt;
        send_word(16'h9512);
        repeat (3) @(negedge clk);
        chk("R3 read starts without data word", 32'(cs_n), 2'b01);
        wait_frames(1, base);
        chk("R4 read direction bit", 32'(last_rw), 1);
        chk("R4 read data bits zero", 32'(last_data), 0);
        chk("R9 select low time", 32'(last_run), 32'(34 * HALF));
        chk("R7 one rd pulse", 32'(rd_cnt - rb), 1);
        chk("R7 R6 read back zero-extended", 32'(last_rd), 16'h0077);
    endtask

    task automatic t_chip0();
        int base = frame_cnt;
        send_word(16'h14A5);
        send_word(16'hFFC3);
        wait_frames(1, base);
        chk("R5 chip 0 selected", 32'(last_chip), 0);
        chk("R5 chip 1 untouched", 32'(smem[1][8'hA5]), 32'(init_val(1, 8'hA5)));
        base = frame_cnt;
        send_word(16'h94A5);
        wait_frames(1, base);
        chk("R7 chip 0 read", 32'(last_rd), 16'h00C3);
        base = frame_cnt;
        send_word(16'h9466);
        wait_frames(1, base);
        chk("R7 preset byte read", 32'(last_rd), 32'(init_val(0, 8'h66)));
    endtask

    task automatic t_busy_ignore();
        int base = frame_cnt;
        send_word(16'h9500);
        repeat (4) @(negedge clk);
        chk("R8 busy flag low", 32'(hw_ready), 0);
        hw_valid = 1'b1;
        hw_word  = 16'h1533;
        repeat (6) @(negedge clk);
        hw_valid = 1'b0;
        wait_frames(1, base);
        chk("R8 one frame only", 32'(frame_cnt - base), 1);
        chk("R8 first read value", 32'(last_rd), 32'(init_val(1, 0)));
        repeat (10) @(negedge clk);
        chk("R8 no stray frame", 32'(cs_n), 2'b11);
        base = frame_cnt;
        send_word(16'h9533);
        wait_frames(1, base);
        chk("R8 next word is an address", 32'(last_rw), 1);
        chk("R8 next word address", 32'(last_addr), 8'h33);
        chk("R8 slave unchanged", 32'(smem[1][8'h33]), 32'(init_val(1, 8'h33)));
    endtask

    task automatic t_back_to_back();
        int base = frame_cnt;
        int rb = rd_cnt;
        send_word(16'h9501);
        send_word(16'h9402);
        wait_frames(2, base);
        chk("R8 queued word gives second frame", 32'(frame_cnt - base), 2);
        chk("R7 two rd pulses", 32'(rd_cnt - rb), 2);
        chk("R7 first of pair", 32'(prev_rd), 32'(init_val(1, 1)));
        chk("R7 second of pair", 32'(last_rd), 32'(init_val(0, 2)));
        chk("R5 second on chip 0", 32'(last_chip), 0);
        chk("R9 second frame length", 32'(last_run), 32'(34 * HALF));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_then_read_chip1();
        t_chip0();
        t_busy_ignore();
        t_back_to_back();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule